// File: doc/BRIEF.md
# Composite Sync Equalization and Serration Inserter

This block merges separately generated horizontal and vertical timing components into one composite sync and one composite blank signal for a raster video timing chain. Both outputs are active-high and registered. Output polarity is applied downstream. The line counter, the frame counter, the component sync and blank pulses, and the programmed timing values all arrive as inputs. The block only combines them and reshapes them.

Within a programmable band of frame-counter values, the ordinary horizontal sync pulse is dropped and a stream of synthetic pulses takes its place. While vertical sync is inactive, these are narrow equalization pulses. While vertical sync is active, they are wide inverted serration pulses.

The pulse stream repeats once per line in single-rate mode and twice per line in double-rate mode. In double-rate mode, the second half of each line is folded onto the first: the half-line length is subtracted from the line position before the position is compared with the pulse edges.

Top module: `cs_eqser_inserter`

## Requirements
- R1: `cblank` equals `h_blank | v_blank` sampled one clock earlier.
- R2: When `comp_en` is 0, or `eqser_off` is 1, or `vcount` is outside the window, `csync` equals `h_sync | v_sync` sampled one clock earlier.
- R3: `rate_mode` is decoded as follows:
  - 2'b00 selects interlaced double-rate.
  - 2'b01 selects non-interlaced double-rate.
  - 2'b11 selects non-interlaced single-rate.
  - 2'b10 is behaves exactly like 2'b01.
  - Pulses are produced in interlaced mode with no field qualification.
- R4: Inside the window with `v_sync` at 0, `csync` is 1 exactly when the phase lies in `[front_porch, eq_end)`.
- R5: Inside the window with `v_sync` at 1, `csync` is 1 exactly when the phase is at least `ser_end` or below `front_porch`.
- R6: The phase depends on the rate mode:
  - In double-rate mode, the phase is `hcount - line_len/2` when `hcount > line_len/2`, and `hcount` otherwise.
  - In single-rate mode, the phase is `hcount`.
- R7: The window is active when `win_start <= vcount < win_end`. The start line is included and the end line is excluded.
- R8: While `rst_n` is 0, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hcount | input | CW | Position within the line, counting from 1 |
| vcount | input | CW | Position within the frame |
| h_sync | input | 1 | Horizontal sync component, active high |
| v_sync | input | 1 | Vertical sync component, active high |
| h_blank | input | 1 | Horizontal blank component, active high |
| v_blank | input | 1 | Vertical blank component, active high |
| rate_mode | input | 2 | Pulse rate and scan mode code |
| eqser_off | input | 1 | 1 suppresses pulse insertion |
| comp_en | input | 1 | 1 selects composite output mode |
| line_len | input | CW | Clocks per line (even) |
| front_porch | input | CW | Leading edge of the equalization pulse; trailing edge of the serration pulse |
| eq_end | input | CW | Trailing edge of the equalization pulse |
| ser_end | input | CW | Leading edge of the serration pulse |
| win_start | input | CW | First frame count of the insertion window |
| win_end | input | CW | Frame count just past the insertion window |
| csync | output | 1 | Composite sync, active high, registered |
| cblank | output | 1 | Composite blank, active high, registered |

## Verification
Pulse-shape selection and phase folding can act in the same cycle. A line position in the second half of the line selects either a folded or an unfolded comparison, depending on the rate code.

Vectors drive one second-half position (`hcount` 70) with vertical sync active, first under code 2'b10 and then under 2'b11. The expected outputs differ: a gap in the first case and a serration pulse in the second. This shows whether the illegal code was folded like the double-rate case.

The window edges are judged the same way. An equalization phase is placed on the start line, the last line and the end line. The block must switch between the inserted pulse and the plain sync OR exactly at those edges.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef enum logic [1:0] {
    MODE_IL_DBL = 2'b00,
    MODE_NI_DBL = 2'b01,
    MODE_BAD    = 2'b10,
    MODE_NI_SGL = 2'b11
  } rate_mode_e;

  // Double-rate for every code except single-rate; the illegal code folds into double
  function automatic logic is_double(input logic [1:0] code);
    return code != MODE_NI_SGL;
  endfunction

  function automatic logic is_interlaced(input logic [1:0] code);
    return code == MODE_IL_DBL;
  endfunction

endpackage

// File: rtl/cs_phase.sv
module cs_phase #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] hcount,
  input  logic [CW-1:0] line_len,
  input  logic          dbl,
  output logic [CW-1:0] half,
  output logic [CW-1:0] phase
);

  function automatic logic [CW-1:0] fold(input logic [CW-1:0] pos,
                                         input logic [CW-1:0] mid,
                                         input logic          en);
    if (en && (pos > mid)) return pos - mid;
    return pos;
  endfunction

  assign half  = line_len >> 1;
  assign phase = fold(hcount, half, dbl);

endmodule

// File: rtl/cs_shape.sv
module cs_shape #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] phase,
  input  logic [CW-1:0] front_porch,
  input  logic [CW-1:0] eq_end,
  input  logic [CW-1:0] ser_end,
  output logic          eq_on,
  output logic          ser_on
);

  function automatic logic in_span(input logic [CW-1:0] p,
                                   input logic [CW-1:0] lo,
                                   input logic [CW-1:0] hi);
    return (p >= lo) && (p < hi);
  endfunction

  // Narrow pulse opens at the front porch
  assign eq_on  = in_span(phase, front_porch, eq_end);
  // Wide pulse runs from ser_end across the half-line boundary to the front porch
  assign ser_on = (phase >= ser_end) || (phase < front_porch);

endmodule

// File: rtl/cs_window.sv
module cs_window #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] vcount,
  input  logic [CW-1:0] win_start,
  input  logic [CW-1:0] win_end,
  input  logic          comp_en,
  input  logic          eqser_off,
  output logic          in_win,
  output logic          ins_active
);

  assign in_win     = (vcount >= win_start) && (vcount < win_end);
  assign ins_active = in_win && comp_en && !eqser_off;

endmodule

// File: rtl/cs_eqser_inserter.sv
module cs_eqser_inserter
  import cs_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] hcount,
  input  logic [CW-1:0] vcount,
  input  logic          h_sync,
  input  logic          v_sync,
  input  logic          h_blank,
  input  logic          v_blank,
  input  logic [1:0]    rate_mode,
  input  logic          eqser_off,
  input  logic          comp_en,
  input  logic [CW-1:0] line_len,
  input  logic [CW-1:0] front_porch,
  input  logic [CW-1:0] eq_end,
  input  logic [CW-1:0] ser_end,
  input  logic [CW-1:0] win_start,
  input  logic [CW-1:0] win_end,
  output logic          csync,
  output logic          cblank
);

  // Named internal events, visible to the bound checker
  logic          dbl;
  logic          interlaced;
  logic [CW-1:0] half;
  logic [CW-1:0] phase;
  logic          eq_on;
  logic          ser_on;
  logic          in_win;
  logic          ins_active;
  logic          plain_sync;
  logic          shaped_sync;
  logic          sync_nxt;
  logic          blank_nxt;

  assign dbl        = is_double(rate_mode);
  // Interlaced scan needs no field qualification here: both fields get pulses
  assign interlaced = is_interlaced(rate_mode);

  cs_phase #(.CW(CW)) u_phase (
    .hcount   (hcount),
    .line_len (line_len),
    .dbl      (dbl),
    .half     (half),
    .phase    (phase)
  );

  cs_shape #(.CW(CW)) u_shape (
    .phase       (phase),
    .front_porch (front_porch),
    .eq_end      (eq_end),
    .ser_end     (ser_end),
    .eq_on       (eq_on),
    .ser_on      (ser_on)
  );

  cs_window #(.CW(CW)) u_win (
    .vcount     (vcount),
    .win_start  (win_start),
    .win_end    (win_end),
    .comp_en    (comp_en),
    .eqser_off  (eqser_off),
    .in_win     (in_win),
    .ins_active (ins_active)
  );

  assign plain_sync  = h_sync | v_sync;
  assign shaped_sync = v_sync ? ser_on : eq_on;
  assign sync_nxt    = ins_active ? shaped_sync : plain_sync;
  assign blank_nxt   = h_blank | v_blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csync  <= 1'b0;
      cblank <= 1'b0;
    end else begin
      csync  <= sync_nxt;
      cblank <= blank_nxt;
    end
  end

endmodule

// File: rtl/cs_eqser_checker.sv
module cs_eqser_checker #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_sync,
  input logic          v_sync,
  input logic          h_blank,
  input logic          v_blank,
  input logic          ins_active,
  input logic          dbl,
  input logic [CW-1:0] half,
  input logic [CW-1:0] phase,
  input logic [CW-1:0] front_porch,
  input logic          csync,
  input logic          cblank
);

  // R1: any blank component forces composite blank on the next clock
  p_blank_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (h_blank || v_blank) |=> cblank);

  // R1: no blank component means no composite blank on the next clock
  p_blank_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_blank && !v_blank) |=> !cblank);

  // R2: without insertion, horizontal sync reaches the output
  p_plain_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_active && h_sync) |=> csync);

  // R4: before the front porch, the equalization pulse holds sync low
  p_eq_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_active && !v_sync && (phase < front_porch)) |=> !csync);

  // R5: before the front porch, the serration pulse holds sync high
  p_ser_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_active && v_sync && (phase < front_porch)) |=> csync);

  // R6: a folded phase never passes the half-line point
  p_phase_fold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dbl |-> (phase <= half));

  // R8: outputs stay cleared while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r8: assert (!csync && !cblank);
    end
  end

endmodule

bind cs_eqser_inserter cs_eqser_checker #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .h_sync      (h_sync),
  .v_sync      (v_sync),
  .h_blank     (h_blank),
  .v_blank     (v_blank),
  .ins_active  (ins_active),
  .dbl         (dbl),
  .half        (half),
  .phase       (phase),
  .front_porch (front_porch),
  .csync       (csync),
  .cblank      (cblank)
);

// File: tb/cs_eqser_inserter_bench.sv
module cs_eqser_inserter_bench;

  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] hcount = '0;
  logic [CW-1:0] vcount = '0;
  logic          h_sync = 1'b0;
  logic          v_sync = 1'b0;
  logic          h_blank = 1'b0;
  logic          v_blank = 1'b0;
  logic [1:0]    rate_mode = 2'b00;
  logic          eqser_off = 1'b0;
  logic          comp_en = 1'b1;
  logic [CW-1:0] line_len = 12'd100;
  logic [CW-1:0] front_porch = 12'd5;
  logic [CW-1:0] eq_end = 12'd9;
  logic [CW-1:0] ser_end = 12'd42;
  logic [CW-1:0] win_start = 12'd10;
  logic [CW-1:0] win_end = 12'd19;
  logic          csync;
  logic          cblank;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cs_eqser_inserter #(.CW(CW)) u_cs_eqser_inserter (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
    .h_sync(h_sync), .v_sync(v_sync), .h_blank(h_blank), .v_blank(v_blank),
    .rate_mode(rate_mode), .eqser_off(eqser_off), .comp_en(comp_en),
    .line_len(line_len), .front_porch(front_porch), .eq_end(eq_end),
    .ser_end(ser_end), .win_start(win_start), .win_end(win_end),
    .csync(csync), .cblank(cblank)
  );

  typedef struct packed {
    logic [7:0]    req;
    logic [CW-1:0] hc;
    logic [CW-1:0] vc;
    logic          hs;
    logic          vs;
    logic          hb;
    logic          vb;
    logic [1:0]    mode;
    logic          off;
    logic          comp;
    logic          exp_sync;
    logic          exp_blank;
  } vec_t;

  // Fixed timing: line 100 (half 50), porch 5, eq end 9, ser end 42, window [10,19)
  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{8'd2, 12'd6,  12'd5,  1'b0,1'b0,1'b0,1'b0, 2'b00,1'b0,1'b1, 1'b0,1'b0}, // R2 outside window
    '{8'd2, 12'd3,  12'd5,  1'b1,1'b0,1'b1,1'b0, 2'b00,1'b0,1'b1, 1'b1,1'b1}, // R2 plain hsync
    '{8'd7, 12'd6,  12'd10, 1'b0,1'b0,1'b0,1'b0, 2'b00,1'b0,1'b1, 1'b1,1'b0}, // R7 start line inside
    '{8'd4, 12'd9,  12'd10, 1'b0,1'b0,1'b0,1'b0, 2'b00,1'b0,1'b1, 1'b0,1'b0}, // R4 eq end exclusive
    '{8'd4, 12'd4,  12'd12, 1'b1,1'b0,1'b0,1'b1, 2'b00,1'b0,1'b1, 1'b0,1'b1}, // R4 hsync replaced
    '{8'd6, 12'd56, 12'd12, 1'b0,1'b0,1'b0,1'b0, 2'b00,1'b0,1'b1, 1'b1,1'b0}, // R6 second eq pulse
    '{8'd6, 12'd56, 12'd12, 1'b0,1'b0,1'b0,1'b0, 2'b11,1'b0,1'b1, 1'b0,1'b0}, // R6 single, no fold
    '{8'd3, 12'd6,  12'd12, 1'b0,1'b0,1'b0,1'b0, 2'b11,1'b0,1'b1, 1'b1,1'b0}, // R3 single eq
    '{8'd5, 12'd50, 12'd14, 1'b0,1'b1,1'b0,1'b1, 2'b01,1'b0,1'b1, 1'b1,1'b1}, // R5 ser at half
    '{8'd5, 12'd51, 12'd14, 1'b0,1'b1,1'b0,1'b1, 2'b01,1'b0,1'b1, 1'b1,1'b1}, // R5 ser wraps
    '{8'd5, 12'd20, 12'd14, 1'b0,1'b1,1'b0,1'b1, 2'b01,1'b0,1'b1, 1'b0,1'b1}, // R5 ser gap
    '{8'd3, 12'd70, 12'd14, 1'b0,1'b1,1'b0,1'b0, 2'b10,1'b0,1'b1, 1'b0,1'b0}, // R3 illegal -> double
    '{8'd3, 12'd70, 12'd14, 1'b0,1'b1,1'b0,1'b0, 2'b11,1'b0,1'b1, 1'b1,1'b0}, // R3 single ser
    '{8'd3, 12'd20, 12'd14, 1'b0,1'b1,1'b0,1'b0, 2'b00,1'b0,1'b1, 1'b0,1'b0}, // R3 interlaced ser gap
    '{8'd7, 12'd6,  12'd19, 1'b0,1'b0,1'b0,1'b0, 2'b00,1'b0,1'b1, 1'b0,1'b0}, // R7 end exclusive
    '{8'd7, 12'd6,  12'd18, 1'b0,1'b0,1'b0,1'b0, 2'b00,1'b0,1'b1, 1'b1,1'b0}, // R7 last line inside
    '{8'd7, 12'd6,  12'd9,  1'b0,1'b0,1'b0,1'b0, 2'b00,1'b0,1'b1, 1'b0,1'b0}, // R7 before start
    '{8'd2, 12'd6,  12'd12, 1'b0,1'b0,1'b0,1'b0, 2'b00,1'b1,1'b1, 1'b0,1'b0}, // R2 insertion off
    '{8'd2, 12'd6,  12'd12, 1'b0,1'b0,1'b0,1'b0, 2'b00,1'b0,1'b0, 1'b0,1'b0}, // R2 not composite
    '{8'd2, 12'd4,  12'd12, 1'b1,1'b0,1'b0,1'b0, 2'b00,1'b1,1'b1, 1'b1,1'b0}, // R2 off passes hsync
    '{8'd1, 12'd30, 12'd30, 1'b0,1'b0,1'b0,1'b1, 2'b00,1'b0,1'b1, 1'b0,1'b1}  // R1 vblank only
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    hcount = v.hc; vcount = v.vc;
    h_sync = v.hs; v_sync = v.vs; h_blank = v.hb; v_blank = v.vb;
    rate_mode = v.mode; eqser_off = v.off; comp_en = v.comp;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R8: reset holds outputs low even with active inputs
    h_sync = 1'b1; h_blank = 1'b1; v_sync = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 csync in reset", csync, 1'b0);
    check("R8 cblank in reset", cblank, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 blank after reset", cblank, 1'b1);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check($sformatf("R%0d vec %0d csync", VECS[i].req, i), csync, VECS[i].exp_sync);
      check($sformatf("R1 vec %0d cblank", i), cblank, VECS[i].exp_blank);
    end

    // R8: asynchronous reset mid-run clears the outputs
    h_blank = 1'b1; h_sync = 1'b1; eqser_off = 1'b1;
    @(negedge clk);
    check("R2 plain before reset", csync, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R8 async clear csync", csync, 1'b0);
    check("R8 async clear cblank", cblank, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule